// File: doc/BRIEF.md
# External Interrupt Conditioner

This block sits between a set of external interrupt pins and an on-chip interrupt controller. Each pin is asynchronous to the core clock. The block brings each pin into the clock domain with a synchronizer. It then conditions the pin into an active-high request that holds as a level. Each line is configured on its own for edge or level sensing. In edge sensing, software picks rising or falling transitions. In level sensing, software picks active-high or active-low.

Edge events are captured in a per-line latch that holds until software acknowledges it. Level-sensed lines are not latched. Their request simply tracks the qualified input. A per-line mask decides which requests reach the combined interrupt output. The mask is changed only through a set register and a separate clear register, each written with ones.

Software uses a plain register port. A write takes effect on the clock edge where `bus_wr_i` is high. A read is combinational on `bus_addr_i`. This is a control port, so it has no valid/ready handshake. Every access completes in one cycle.

Top module: `eic_top`

## Requirements
- R1: After reset, the sense, direction, polarity and mask registers are all zero, meaning falling-edge sensing with every line masked. `pend_o` is zero and `irq_o` is low.
- R2: Address 0 selects sense (bit=1 level, 0 edge), address 1 selects direction (bit=1 rising, 0 falling) and address 2 selects polarity (bit=1 active-high, 0 active-low). These registers read back what was written in bits [N_LINES-1:0]. Bits for lines that are not implemented read as zero, so writing all ones to address 0 reads back as 2^N_LINES-1.
- R3: A write to address 3 sets the mask bit of each line whose data bit is 1. A write to address 4 clears the mask bit of each line whose data bit is 1. Zero data bits leave their mask bits unchanged. Address 6 reads the mask.
- R4: For an edge-sensed line, a transition in the selected direction sets the line's `pend_o` bit. The input must settle before clock edge k, and the bit reads 1 after edge k+2 and still 0 after edge k+1. Transitions in the other direction do not set it.
- R5: A latched edge bit stays set after the input returns. It is cleared only by a write of 1 to that line's bit at address 5, the acknowledge register.
- R6: If a new selected edge is detected in the same cycle as an acknowledge write to that line, the pending bit stays set.
- R7: For a level-sensed line, `pend_o` equals the synchronized input (active-high) or its inverse (active-low), two clock edges after the input changes. An acknowledge write has no lasting effect on it.
- R8: `pend_o` is not masked. Address 7 reads `pend_o & mask`, and `irq_o` is the OR of those bits.
- R9: Addresses 3, 4, 5 and 8 to 15 read as zero. Writes to addresses 6, 7 and 8 to 15 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq_i | input | N_LINES | Asynchronous external interrupt pins |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Combinational read data for `bus_addr_i` |
| pend_o | output | N_LINES | Unmasked per-line request toward the interrupt controller |
| irq_o | output | 1 | OR of the masked pending bits |

## Verification
The checker watches four things on every cycle:
- a latched edge bit never drops unless an acknowledge write hit it;
- a detected edge on an edge-sensed line always shows up as pending on the next cycle, even when an acknowledge write arrives at the same time;
- the mask moves only on set or clear writes;
- the status read and the write-only reads agree with pending, mask and zero.

Some behaviour only the directed scenarios can show:
- the exact two- and three-edge latency from a pin change;
- the polarity and direction choices;
- the read-back width that reveals the line count;
- the fact that an acknowledge cannot hold down an asserted level.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    REG_SENSE  = 4'd0,
    REG_DIR    = 4'd1,
    REG_POL    = 4'd2,
    REG_EN_SET = 4'd3,
    REG_EN_CLR = 4'd4,
    REG_ACK    = 4'd5,
    REG_MASK   = 4'd6,
    REG_STATUS = 4'd7
  } reg_sel_e;
endpackage

// File: rtl/eic_sync.sv
// Per-line synchronizer plus one history stage for edge detection.
module eic_sync #(
  parameter int N_LINES = 8,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] pin_i,
  output logic [N_LINES-1:0] cur_o,
  output logic [N_LINES-1:0] prev_o
);
  localparam int DEPTH = STAGES + 1;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [DEPTH-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[DEPTH-2:0], pin_i[g]};
    end
    assign cur_o[g]  = chain_q[STAGES-1];
    assign prev_o[g] = chain_q[STAGES];
  end
endmodule

// File: rtl/eic_line_cond.sv
// One line: edge latch or transparent level qualification.
module eic_line_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic cur_i,
  input  logic prev_i,
  input  logic sense_i,
  input  logic dir_i,
  input  logic pol_i,
  input  logic ack_i,
  output logic pend_o
);
  logic hit;
  logic latch_q;

  assign hit = dir_i ? (cur_i & ~prev_i) : (~cur_i & prev_i);

  always_ff @(posedge clk) begin
    if (!rst_n)       latch_q <= 1'b0;
    else if (sense_i) latch_q <= 1'b0;
    else              latch_q <= hit | (latch_q & ~ack_i);
  end

  assign pend_o = sense_i ? (cur_i ~^ pol_i) : latch_q;
endmodule

// File: rtl/eic_regs.sv
module eic_regs
  import eic_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_i,
  input  logic [REG_AW-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [N_LINES-1:0] pend_i,
  output logic [N_LINES-1:0] sense_o,
  output logic [N_LINES-1:0] dir_o,
  output logic [N_LINES-1:0] pol_o,
  output logic [N_LINES-1:0] mask_o,
  output logic [N_LINES-1:0] ack_o,
  output logic [DATA_W-1:0]  rdata_o
);
  logic [N_LINES-1:0] wbits;
  logic [N_LINES-1:0] sense_q, dir_q, pol_q, mask_q;

  assign wbits = wdata_i[N_LINES-1:0];

  if (DATA_W > N_LINES) begin : g_hi
    logic unused_hi;
    assign unused_hi = ^wdata_i[DATA_W-1:N_LINES];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sense_q <= '0;
      dir_q   <= '0;
      pol_q   <= '0;
      mask_q  <= '0;
    end else if (wr_i) begin
      case (addr_i)
        REG_SENSE:  sense_q <= wbits;
        REG_DIR:    dir_q   <= wbits;
        REG_POL:    pol_q   <= wbits;
        REG_EN_SET: mask_q  <= mask_q | wbits;
        REG_EN_CLR: mask_q  <= mask_q & ~wbits;
        default: ;
      endcase
    end
  end

  assign ack_o   = (wr_i && addr_i == REG_ACK) ? wbits : '0;
  assign sense_o = sense_q;
  assign dir_o   = dir_q;
  assign pol_o   = pol_q;
  assign mask_o  = mask_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_SENSE:  rdata_o[N_LINES-1:0] = sense_q;
      REG_DIR:    rdata_o[N_LINES-1:0] = dir_q;
      REG_POL:    rdata_o[N_LINES-1:0] = pol_q;
      REG_MASK:   rdata_o[N_LINES-1:0] = mask_q;
      REG_STATUS: rdata_o[N_LINES-1:0] = pend_i & mask_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/eic_top.sv
module eic_top
  import eic_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int DATA_W  = 32,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] ext_irq_i,
  input  logic               bus_wr_i,
  input  logic [REG_AW-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic [N_LINES-1:0] pend_o,
  output logic               irq_o
);
  logic [N_LINES-1:0] line_cur, line_prev;
  logic [N_LINES-1:0] cfg_sense, cfg_dir, cfg_pol, mask_q, ack_v;

  eic_sync #(.N_LINES(N_LINES), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_irq_i),
    .cur_o(line_cur), .prev_o(line_prev)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_cond
    eic_line_cond u_cond (
      .clk(clk), .rst_n(rst_n),
      .cur_i(line_cur[g]), .prev_i(line_prev[g]),
      .sense_i(cfg_sense[g]), .dir_i(cfg_dir[g]), .pol_i(cfg_pol[g]),
      .ack_i(ack_v[g]), .pend_o(pend_o[g])
    );
  end

  eic_regs #(.N_LINES(N_LINES), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_i(bus_wr_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .pend_i(pend_o),
    .sense_o(cfg_sense), .dir_o(cfg_dir), .pol_o(cfg_pol),
    .mask_o(mask_q), .ack_o(ack_v), .rdata_o(bus_rdata_o)
  );

  assign irq_o = |(pend_o & mask_q);
endmodule

// File: rtl/eic_checks.sv
module eic_checks
  import eic_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr_i,
  input logic [REG_AW-1:0]  bus_addr_i,
  input logic [DATA_W-1:0]  bus_wdata_i,
  input logic [DATA_W-1:0]  bus_rdata_o,
  input logic [N_LINES-1:0] pend_o,
  input logic               irq_o,
  input logic [N_LINES-1:0] cfg_sense,
  input logic [N_LINES-1:0] cfg_dir,
  input logic [N_LINES-1:0] mask_q,
  input logic [N_LINES-1:0] line_cur,
  input logic [N_LINES-1:0] line_prev
);
  logic [N_LINES-1:0] ack_seen, hit_seen;
  logic [DATA_W-1:0]  status_exp;

  assign ack_seen = (bus_wr_i && bus_addr_i == REG_ACK) ? bus_wdata_i[N_LINES-1:0] : '0;
  assign hit_seen = (line_cur & ~line_prev & cfg_dir) | (~line_cur & line_prev & ~cfg_dir);

  always_comb begin
    status_exp = '0;
    status_exp[N_LINES-1:0] = pend_o & mask_q;
  end

  // R5: latched edge bits survive until acknowledged
  a_r5_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend_o & ~cfg_sense & ~ack_seen) & ~cfg_sense & ~pend_o) == '0));

  // R4 and R6: a detected edge is pending next cycle, even against an acknowledge
  a_r6_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(hit_seen & ~cfg_sense) & ~cfg_sense & ~pend_o) == '0));

  // R3: mask only moves on set/clear writes
  a_r3_mask_writes_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_i && (bus_addr_i == REG_EN_SET || bus_addr_i == REG_EN_CLR)) |=> $stable(mask_q));

  // R8: status read agrees with pending and mask; irq needs an enabled line
  a_r8_status_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_i == REG_STATUS) |-> (bus_rdata_o == status_exp));

  a_r8_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (mask_q != '0));

  // R9: write-only and unused addresses read zero
  a_r9_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_i == REG_EN_SET || bus_addr_i == REG_EN_CLR || bus_addr_i == REG_ACK ||
     bus_addr_i[3]) |-> (bus_rdata_o == '0));
endmodule

bind eic_top eic_checks #(.N_LINES(N_LINES), .DATA_W(DATA_W)) u_checks (
  .clk(clk), .rst_n(rst_n),
  .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
  .bus_rdata_o(bus_rdata_o), .pend_o(pend_o), .irq_o(irq_o),
  .cfg_sense(cfg_sense), .cfg_dir(cfg_dir), .mask_q(mask_q),
  .line_cur(line_cur), .line_prev(line_prev)
);

// File: tb/tb_eic_top.sv
module tb_eic_top;
  localparam int N = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  ext = '0;
  logic          wr = 1'b0;
  logic [3:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [N-1:0]  pend;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  eic_top #(.N_LINES(N), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .ext_irq_i(ext),
    .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .pend_o(pend), .irq_o(irq)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [DW-1:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    step(1);
    check("R1 pend", pend, 0);
    check("R1 irq", irq, 0);
    bus_read(0, d); check("R1 sense", d, 0);
    bus_read(1, d); check("R1 dir", d, 0);
    bus_read(2, d); check("R1 pol", d, 0);
    bus_read(6, d); check("R1 mask", d, 0);
  endtask

  task automatic t_cfg_rw();
    logic [DW-1:0] d;
    bus_write(0, 32'hFFFF_FFFF);
    bus_read(0, d); check("R2 sense width", d, 32'h0000_00FF);
    bus_write(0, 32'h0);
    bus_write(1, 32'h1234_56A5);
    bus_read(1, d); check("R2 dir", d, 32'h0000_00A5);
    bus_write(2, 32'h0000_003C);
    bus_read(2, d); check("R2 pol", d, 32'h0000_003C);
    bus_write(1, 32'h0);
    bus_write(2, 32'h0);
  endtask

  task automatic t_mask();
    logic [DW-1:0] d;
    bus_write(3, 32'h0000_0081);
    bus_write(3, 32'h0000_0004);
    bus_read(6, d); check("R3 set accumulates", d, 32'h85);
    bus_write(4, 32'h0000_0001);
    bus_read(6, d); check("R3 clear one", d, 32'h84);
    bus_write(4, 32'h0000_0084);
    bus_read(6, d); check("R3 clear rest", d, 32'h0);
  endtask

  task automatic t_edge_rise();
    bus_write(1, 32'h1);
    ext[0] = 1'b1;
    step(2); check("R4 rise not yet", pend[0], 0);
    step(1); check("R4 rise latched", pend[0], 1);
    ext[0] = 1'b0;
    step(4); check("R5 holds after input drops", pend[0], 1);
    ext[0] = 1'b1;
    step(2);
    wr = 1'b1; addr = 4'd5; wdata = 32'h1;
    step(1);
    wr = 1'b0; wdata = '0;
    check("R6 edge beats ack", pend[0], 1);
    bus_write(5, 32'h1);
    check("R5 ack clears", pend[0], 0);
    ext[0] = 1'b0;
    step(4);
    check("R4 wrong direction ignored", pend[0], 0);
  endtask

  task automatic t_edge_fall();
    ext[1] = 1'b1;
    step(4); check("R4 rise ignored on falling line", pend[1], 0);
    ext[1] = 1'b0;
    step(3); check("R4 fall latched", pend[1], 1);
    bus_write(5, 32'h2);
    check("R5 ack clears fall", pend[1], 0);
  endtask

  task automatic t_level();
    bus_write(2, 32'h4);
    bus_write(0, 32'h4);
    step(3); check("R7 high level idle", pend[2], 0);
    ext[2] = 1'b1;
    step(1); check("R7 not yet", pend[2], 0);
    step(1); check("R7 high follows", pend[2], 1);
    bus_write(5, 32'h4);
    step(1); check("R7 ack no lasting effect", pend[2], 1);
    ext[2] = 1'b0;
    step(2); check("R7 high drops", pend[2], 0);
    bus_write(2, 32'h0);
    check("R7 active-low asserted", pend[2], 1);
    ext[2] = 1'b1;
    step(2); check("R7 active-low released", pend[2], 0);
    ext[2] = 1'b0;
    bus_write(0, 32'h0);
    step(3);
  endtask

  task automatic t_status_irq();
    logic [DW-1:0] d;
    bus_write(1, 32'h1);
    ext[0] = 1'b1;
    step(3);
    bus_write(3, 32'h2);
    check("R8 pend unmasked", pend[0], 1);
    check("R8 irq masked off", irq, 0);
    bus_read(7, d); check("R8 status masked", d, 0);
    bus_write(3, 32'h1);
    check("R8 irq on", irq, 1);
    bus_read(7, d); check("R8 status", d, 32'h1);
    bus_write(4, 32'h1);
    check("R8 irq off after clear", irq, 0);
    bus_write(5, 32'h1);
    ext[0] = 1'b0;
    step(3);
  endtask

  task automatic t_unused();
    logic [DW-1:0] d;
    bus_write(3, 32'h2);
    bus_read(3, d); check("R9 set reads zero", d, 0);
    bus_read(4, d); check("R9 clear reads zero", d, 0);
    bus_read(5, d); check("R9 ack reads zero", d, 0);
    bus_read(9, d); check("R9 unused reads zero", d, 0);
    bus_write(6, 32'hFF);
    bus_write(7, 32'hFF);
    bus_write(12, 32'hFF);
    bus_read(6, d); check("R9 mask untouched", d, 32'h2);
    bus_read(0, d); check("R9 sense untouched", d, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_cfg_rw();
    t_mask();
    t_edge_rise();
    t_edge_fall();
    t_level();
    t_status_irq();
    t_unused();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule